// File: doc/BRIEF.md
# Seeded Pseudo-Random Word Generator Peripheral

This block is a polled, memory-mapped source of pseudo-random words behind a simple 32-bit register bus. Software loads five 32-bit seed words. It then writes the control register with the engine-select bit and the start bit set, and polls the status register until the done flag appears. After that it reads five freshly generated 32-bit output words.

Generation runs only when three conditions hold together: every seed slot has been written since reset, the engine-select bit is set in the write, and the start bit is set in the write. The start bit never stays set.

The generator is a 32-bit maximal-length Galois LFSR. It is loaded with the XOR of the five seed words, and a zero fold is replaced by a fixed nonzero value. It then steps once per clock for five clocks, and each step fills one output word. The status register merges live hardware flags with three software-writable completion flags.

Top module: `seedgen_periph`

## Requirements
- R1: After reset, control reads 0x00000000, status reads 0x00000001 (only bit 0, ready, set) and all five output words read 0.
- R2: Register map by byte offset: control 0x000, status 0x010, seed slots 0x140/0x144/0x148/0x14C/0x150 (write-only, read 0), output words 0x160/0x164/0x168/0x16C/0x170 (read-only). Reads of any other offset return 0. Writes to any other offset, and writes to output words, change nothing.
- R3: Status bit 1 (seeds loaded) reads 1 only once every one of the five seed slots has been written at least once since reset, in any order, with repeats counting once. It then stays 1 until reset.
- R4: A run is launched only by a control write that has bit 3 (engine select) and bit 4 (start) both set while status bit 1 is 1. Any other control write leaves the output words and status bit 5 unchanged.
- R5: Control bit 4 always reads back 0 after a control write. All other written control bits read back as written.
- R6: After a launching write, status bit 2 (busy) reads 1 for exactly five clock cycles. Status bit 5 (done) is set in the cycle busy drops. Launch requests made while busy are ignored.
- R7: The output words are successive states of a right-shifting Galois LFSR with feedback mask 0x80200003: next = (s >> 1) XOR (s[0] ? 0x80200003 : 0). The LFSR starts from the XOR of the five seed words, and 0x5EED0001 is used when that XOR is 0. Word k (k = 0..4, at offset 0x160 + 4k) is the state after k+1 steps.
- R8: A status write replaces bits 5, 4 and 3 with the written bits. Bits 7 (error, always 0), 2, 1 and 0 are not affected by the write.
- R9: Seed slots may be rewritten after a run. The next launch uses the current seed values, and the loaded flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte offset in the 0x200 window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |

## Verification
The generator is run with a seed set that folds to a nonzero value, with a set whose words cancel to zero so that the substitute start state is used, and with a rewritten set after an earlier run. Comparing these runs separates a correct fold from a single-slot or stale-seed load, and shows whether the zero guard works. Launch attempts with only the start bit, only the select bit, or with one seed slot still missing show that all three gate conditions are required. A second launch issued one cycle into a run shows whether busy is extended or restarted instead of being ignored.

// File: rtl/seedgen_pkg.sv
`timescale 1ns/100ps
package seedgen_pkg;
  localparam int WORD_W = 32;

  // control bit positions
  localparam int CTL_SEL_BIT = 3;
  localparam int CTL_GO_BIT  = 4;

  // status bit positions
  localparam int ST_READY_BIT = 0;
  localparam int ST_SEEDS_BIT = 1;
  localparam int ST_BUSY_BIT  = 2;
  localparam int ST_PART_BIT  = 3;
  localparam int ST_MSG_BIT   = 4;
  localparam int ST_DONE_BIT  = 5;
  localparam int ST_ERR_BIT   = 7;

  // one Galois step, right shifting
  function automatic logic [WORD_W-1:0] lfsr_advance(input logic [WORD_W-1:0] s,
                                                     input logic [WORD_W-1:0] mask);
    logic [WORD_W-1:0] shifted;
    shifted = {1'b0, s[WORD_W-1:1]};
    return s[0] ? (shifted ^ mask) : shifted;
  endfunction

  // zero guard on a start state
  function automatic logic [WORD_W-1:0] nonzero_start(input logic [WORD_W-1:0] s,
                                                      input logic [WORD_W-1:0] subst);
    return (s == '0) ? subst : s;
  endfunction
endpackage

// File: rtl/seedgen_seedtrk.sv
`timescale 1ns/100ps
module seedgen_seedtrk
  import seedgen_pkg::*;
#(
  parameter int NUM   = 5,
  parameter int IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  output logic              all_loaded,
  output logic [WORD_W-1:0] seed_fold
);
  logic [NUM-1:0]              loaded_q;
  logic [NUM-1:0][WORD_W-1:0]  seed_q;

  for (genvar i = 0; i < NUM; i++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        loaded_q[i] <= 1'b0;
        seed_q[i]   <= '0;
      end else if (hit) begin
        loaded_q[i] <= 1'b1;
        seed_q[i]   <= wr_data;
      end
    end
  end

  always_comb begin
    seed_fold = '0;
    for (int i = 0; i < NUM; i++) seed_fold = seed_fold ^ seed_q[i];
  end

  assign all_loaded = &loaded_q;

  AST_SEEDS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    all_loaded |=> all_loaded); // R3
endmodule

// File: rtl/seedgen_lfsr.sv
`timescale 1ns/100ps
module seedgen_lfsr
  import seedgen_pkg::*;
#(
  parameter int              NUM   = 5,
  parameter logic [WORD_W-1:0] MASK  = 32'h8020_0003,
  parameter logic [WORD_W-1:0] SUBST = 32'h5EED_0001,
  parameter int              IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] start_val,
  output logic              busy,
  output logic              step_vld,
  output logic [IDX_W-1:0]  step_idx,
  output logic [WORD_W-1:0] step_word,
  output logic              finish
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM - 1);

  logic [WORD_W-1:0] state_q;
  logic [IDX_W-1:0]  cnt_q;
  logic              busy_q;
  logic [WORD_W-1:0] nxt;

  assign nxt = lfsr_advance(state_q, MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
    end else if (load) begin
      state_q <= nonzero_start(start_val, SUBST);
      cnt_q   <= '0;
      busy_q  <= 1'b1;
    end else if (busy_q) begin
      state_q <= nxt;
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy      = busy_q;
  assign step_vld  = busy_q;
  assign step_idx  = cnt_q;
  assign step_word = nxt;
  assign finish    = busy_q && (cnt_q == LAST);

  AST_STATE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (state_q != '0)); // R7
  AST_RUN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !busy_q); // R6
  AST_NO_LOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !load); // R6
endmodule

// File: rtl/seedgen_outbank.sv
`timescale 1ns/100ps
module seedgen_outbank
  import seedgen_pkg::*;
#(
  parameter int NUM   = 5,
  parameter int IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [WORD_W-1:0]          wr_data,
  output logic [NUM-1:0][WORD_W-1:0] words
);
  for (genvar i = 0; i < NUM; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              words[i] <= '0;
      else if (wr_en && wr_idx == IDX_W'(i))  words[i] <= wr_data;
    end
  end
endmodule

// File: rtl/seedgen_periph.sv
`timescale 1ns/100ps
module seedgen_periph
  import seedgen_pkg::*;
#(
  parameter int              ADDR_W    = 9,
  parameter int              NUM       = 5,
  parameter logic [ADDR_W-1:0] CTL_OFF   = 9'h000,
  parameter logic [ADDR_W-1:0] ST_OFF    = 9'h010,
  parameter logic [ADDR_W-1:0] SEED_OFF  = 9'h140,
  parameter logic [ADDR_W-1:0] OUT_OFF   = 9'h160,
  parameter logic [31:0]     LFSR_MASK = 32'h8020_0003,
  parameter logic [31:0]     ZERO_SUB  = 32'h5EED_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1;
  localparam int WA_W  = ADDR_W - 2;
  localparam logic [WA_W-1:0] SEED_WA = SEED_OFF[ADDR_W-1:2];
  localparam logic [WA_W-1:0] OUT_WA  = OUT_OFF[ADDR_W-1:2];

  // decode
  logic            aligned;
  logic [WA_W-1:0] wa, seed_rel, out_rel;
  logic            hit_ctl, hit_st, hit_seed, hit_out;
  logic            wr_ctl, wr_st, wr_seed;

  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign wa       = bus_addr[ADDR_W-1:2];
  assign seed_rel = wa - SEED_WA;
  assign out_rel  = wa - OUT_WA;
  assign hit_ctl  = (bus_addr == CTL_OFF);
  assign hit_st   = (bus_addr == ST_OFF);
  assign hit_seed = aligned && (seed_rel < WA_W'(NUM));
  assign hit_out  = aligned && (out_rel  < WA_W'(NUM));
  assign wr_ctl   = bus_sel && bus_wr && hit_ctl;
  assign wr_st    = bus_sel && bus_wr && hit_st;
  assign wr_seed  = bus_sel && bus_wr && hit_seed;

  // seed tracking
  logic        seeds_ok;
  logic [31:0] fold;

  seedgen_seedtrk #(.NUM(NUM), .IDX_W(IDX_W)) u_seeds (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_seed),
    .wr_idx     (seed_rel[IDX_W-1:0]),
    .wr_data    (bus_wdata),
    .all_loaded (seeds_ok),
    .seed_fold  (fold)
  );

  // launch and generator
  logic             gen_busy, gen_vld, gen_finish, launch;
  logic [IDX_W-1:0] gen_idx;
  logic [31:0]      gen_word;

  assign launch = wr_ctl && bus_wdata[CTL_SEL_BIT] && bus_wdata[CTL_GO_BIT]
                  && seeds_ok && !gen_busy;

  seedgen_lfsr #(.NUM(NUM), .MASK(LFSR_MASK), .SUBST(ZERO_SUB), .IDX_W(IDX_W)) u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (launch),
    .start_val (fold),
    .busy      (gen_busy),
    .step_vld  (gen_vld),
    .step_idx  (gen_idx),
    .step_word (gen_word),
    .finish    (gen_finish)
  );

  logic [NUM-1:0][31:0] out_words;

  seedgen_outbank #(.NUM(NUM), .IDX_W(IDX_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (gen_vld),
    .wr_idx  (gen_idx),
    .wr_data (gen_word),
    .words   (out_words)
  );

  // control register: start bit is never held
  logic [31:0] ctl_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (wr_ctl) ctl_q <= bus_wdata & ~(32'd1 << CTL_GO_BIT);
  end

  // software-writable completion flags; hardware completion wins for done
  logic done_q, msg_q, part_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      msg_q  <= 1'b0;
      part_q <= 1'b0;
    end else begin
      if (wr_st) begin
        done_q <= bus_wdata[ST_DONE_BIT];
        msg_q  <= bus_wdata[ST_MSG_BIT];
        part_q <= bus_wdata[ST_PART_BIT];
      end
      if (gen_finish) done_q <= 1'b1;
    end
  end

  logic [31:0] status;
  always_comb begin
    status               = '0;
    status[ST_READY_BIT] = 1'b1;
    status[ST_SEEDS_BIT] = seeds_ok;
    status[ST_BUSY_BIT]  = gen_busy;
    status[ST_PART_BIT]  = part_q;
    status[ST_MSG_BIT]   = msg_q;
    status[ST_DONE_BIT]  = done_q;
    status[ST_ERR_BIT]   = 1'b0;
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (hit_ctl)      bus_rdata = ctl_q;
    else if (hit_st)  bus_rdata = status;
    else if (hit_out) bus_rdata = out_words[out_rel[IDX_W-1:0]];
  end

  AST_LAUNCH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> seeds_ok); // R4
  AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gen_busy) |-> done_q); // R6
  AST_BUSY_AFTER_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> gen_busy); // R6
  AST_GO_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> !ctl_q[CTL_GO_BIT]); // R5
endmodule

// File: tb/seedgen_periph_test.sv
`timescale 1ns/100ps
module seedgen_periph_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  seedgen_periph uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata)
  );

  logic [31:0] exp_w [5];

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %08h expected %08h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1;
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [8:0] a, output logic [31:0] v);
    addr = a;
    #0.2;
    v = rdata;
  endtask

  task automatic rd_chk(input string req, input string what,
                        input logic [8:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_read(a, v);
    chk(req, what, v, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic put_seeds(input logic [31:0] a, b, c, d, e);
    bus_write(9'h140, a);
    bus_write(9'h144, b);
    bus_write(9'h148, c);
    bus_write(9'h14C, d);
    bus_write(9'h150, e);
  endtask

  // bench model: Galois LFSR, mask 0x80200003, zero fold -> 0x5EED0001
  task automatic model(input logic [31:0] a, b, c, d, e);
    logic [31:0] s;
    s = a ^ b ^ c ^ d ^ e;
    if (s == 32'd0) s = 32'h5EED_0001;
    for (int k = 0; k < 5; k++) begin
      logic lsb;
      lsb = s[0];
      s = s >> 1;
      if (lsb) s = s ^ 32'h8020_0003;
      exp_w[k] = s;
    end
  endtask

  task automatic chk_words(input string req);
    for (int k = 0; k < 5; k++)
      rd_chk(req, $sformatf("out word %0d", k), 9'(9'h160 + 4 * k), exp_w[k]);
  endtask

  task automatic chk_zero_words(input string req);
    for (int k = 0; k < 5; k++)
      rd_chk(req, $sformatf("out word %0d", k), 9'(9'h160 + 4 * k), 32'd0);
  endtask

  // launch then follow busy cycle by cycle
  task automatic run_and_track(input string req);
    logic [31:0] v;
    bus_write(9'h000, 32'h18);
    bus_read(9'h010, v);
    chk(req, "busy after launch", v[2], 1'b1);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      bus_read(9'h010, v);
      chk(req, $sformatf("busy cycle %0d", i + 2), v[2], 1'b1);
    end
    @(posedge clk); #1;
    bus_read(9'h010, v);
    chk(req, "busy dropped", v[2], 1'b0);
    chk(req, "done on drop", v[5], 1'b1);
  endtask

  task automatic t_reset();
    rd_chk("R1", "control", 9'h000, 32'h0);
    rd_chk("R1", "status", 9'h010, 32'h1);
    chk_zero_words("R1");
  endtask

  task automatic t_decode();
    bus_write(9'h140, 32'hDEAD_BEEF);
    rd_chk("R2", "seed read", 9'h140, 32'h0);
    rd_chk("R2", "unmapped 0x004", 9'h004, 32'h0);
    rd_chk("R2", "unmapped 0x1FC", 9'h1FC, 32'h0);
    bus_write(9'h164, 32'h1234_5678);
    rd_chk("R2", "output write ignored", 9'h164, 32'h0);
    bus_write(9'h020, 32'hFFFF_FFFF);
    bus_write(9'h154, 32'hFFFF_FFFF);
    rd_chk("R2", "status after stray writes", 9'h010, 32'h1);
    rd_chk("R2", "control after stray writes", 9'h000, 32'h0);
  endtask

  task automatic t_gate_no_seeds();
    bus_write(9'h000, 32'h18);
    @(negedge clk);
    rd_chk("R4", "status without seeds", 9'h010, 32'h1);
    chk_zero_words("R4");
    rd_chk("R5", "start bit cleared", 9'h000, 32'h08);
  endtask

  task automatic t_seeds();
    logic [31:0] v;
    bus_write(9'h14C, 32'h1);
    bus_write(9'h144, 32'h2);
    bus_write(9'h140, 32'h3);
    bus_write(9'h140, 32'h4);
    bus_write(9'h148, 32'h5);
    bus_read(9'h010, v);
    chk("R3", "seeds bit with one slot missing", v[1], 1'b0);
    bus_write(9'h150, 32'h6);
    rd_chk("R3", "status all seeds", 9'h010, 32'h3);
  endtask

  task automatic t_gate_bits();
    bus_write(9'h000, 32'h10);
    @(negedge clk);
    rd_chk("R4", "start only", 9'h010, 32'h3);
    rd_chk("R5", "start only readback", 9'h000, 32'h0);
    bus_write(9'h000, 32'hA8);
    @(negedge clk);
    rd_chk("R4", "select only", 9'h010, 32'h3);
    chk_zero_words("R4");
    rd_chk("R5", "other bits kept", 9'h000, 32'hA8);
  endtask

  task automatic t_run();
    put_seeds(32'h1357_9BDF, 32'h0246_8ACE, 32'hFEDC_BA98, 32'h7654_3210, 32'hA5A5_0F0F);
    model(32'h1357_9BDF, 32'h0246_8ACE, 32'hFEDC_BA98, 32'h7654_3210, 32'hA5A5_0F0F);
    run_and_track("R6");
    chk_words("R7");
    rd_chk("R5", "control after run", 9'h000, 32'h08);
    rd_chk("R6", "status after run", 9'h010, 32'h23);
  endtask

  task automatic t_status_write();
    bus_write(9'h010, 32'hFFFF_FFFF);
    rd_chk("R8", "status all ones written", 9'h010, 32'h3B);
    bus_write(9'h010, 32'h0);
    rd_chk("R8", "status zeros written", 9'h010, 32'h03);
    bus_write(9'h010, 32'h10);
    rd_chk("R8", "only msg flag", 9'h010, 32'h13);
    bus_write(9'h010, 32'h0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    put_seeds(32'h0000_0001, 32'h0, 32'h0, 32'h0, 32'h8000_0000);
    model(32'h0000_0001, 32'h0, 32'h0, 32'h0, 32'h8000_0000);
    bus_write(9'h000, 32'h18);
    bus_write(9'h000, 32'h18);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      bus_read(9'h010, v);
      chk("R6", $sformatf("busy held %0d", i + 3), v[2], 1'b1);
    end
    @(posedge clk); #1;
    bus_read(9'h010, v);
    chk("R6", "second start ignored, busy ends on time", v[2], 1'b0);
    chk_words("R9");
  endtask

  task automatic t_zero_fold();
    logic [31:0] v;
    bus_write(9'h010, 32'h0);
    put_seeds(32'hCAFE_F00D, 32'hCAFE_F00D, 32'h0BAD_1DEA, 32'h0BAD_1DEA, 32'h0);
    model(32'h0, 32'h0, 32'h0, 32'h0, 32'h0);
    bus_read(9'h010, v);
    chk("R9", "seeds bit kept after reseed", v[1], 1'b1);
    run_and_track("R6");
    chk_words("R7");
  endtask

  task automatic t_reset_again();
    logic [31:0] v;
    do_reset();
    t_reset();
    bus_write(9'h148, 32'h77);
    bus_read(9'h010, v);
    chk("R3", "flags cleared by reset", v[1], 1'b0);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    do_reset();
    t_reset();
    t_decode();
    t_gate_no_seeds();
    t_seeds();
    t_gate_bits();
    t_run();
    t_status_write();
    t_busy_ignore();
    t_zero_fold();
    t_reset_again();
    repeat (2) @(posedge clk);
    finish_up();
  end
endmodule